// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This engine delivers received frames into system memory through linked lists of receive descriptors kept in memory. Software owns up to four rings. It hands a descriptor to the engine by setting the ownership bit. It points each ring at its first descriptor through a register write. When a frame header arrives, the engine searches the rings from the lowest index upward. In each ring it follows the next links, starting at the ring's current position. It takes the first descriptor that it owns and whose buffer can hold the frame.

The frame words are stored at the descriptor's buffer address plus a programmable header gap. The engine then writes two descriptor words back: ownership is released and the byte count is recorded. The ring's current position advances to the next link. A receive interrupt cause is set, and the interrupt output follows the cause gated by its mask. If no ring can take the frame, its words are still consumed from the input, nothing is written to memory, and a drop counter increments.

Memory is reached through a single 32-bit word master with a request/acknowledge handshake. Configuration and status use a word-indexed register port whose read data is combinational.

Top module: `rx_ring_dma`

## Requirements
- R1: A register write to index r (0 to NUM_RINGS-1) loads both ring r's start pointer and its current pointer with the written value. The start pointer reads back at index r and the current pointer at index 4+r. A register write takes priority over an advance of the same ring in the same cycle.
- R2: A descriptor occupies four consecutive 32-bit words at its address. Word 0 holds command/status, with the ownership bit at bit 31. Word 1 holds the byte count in bits 15:0 and the buffer size in bits 31:16. Word 2 holds the buffer address and word 3 holds the next-descriptor address.
- R3: Rings are searched in ascending index order. A ring whose current pointer is zero is skipped. The search ends at the first accepted descriptor, so a lower ring wins over a higher one.
- R4: Within a ring, the walk starts at the current pointer and follows next links. It leaves the ring when a descriptor's next address equals the ring's start pointer, or after MAX_WALK descriptors.
- R5: A descriptor is accepted only when bit 31 of word 0 is set and its buffer size is greater than or equal to the frame length. Equal size is accepted.
- R6: An accepted frame of L bytes is written as ceil(L/4) consecutive words starting at buffer address plus header offset. The header offset is register 10, in bytes, and its bits 1:0 always read zero.
- R7: After the data, word 0 is written back with bit 31 cleared and all other bits kept. Word 1 is then written as {buffer size, L + header offset}. After these writes, the ring's current pointer becomes the descriptor's next address.
- R8: Acceptance sets receive cause bit 0, which is register 8. Writing a one to that bit clears it, but a new acceptance in the same cycle wins. The mask is register 9, bit 0. The irq output is high exactly when cause and mask are both set.
- R9: When no descriptor is accepted, all words of the frame are consumed, no memory write happens, the cause is unchanged, and the drop counter (register 11) increments by one.
- R10: A memory request keeps its address, direction and data steady until acknowledged. Only one frame is handled at a time: hdr_ready is high only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Frame header present |
| hdr_ready | output | 1 | Engine idle, header accepted |
| hdr_len | input | 16 | Frame length in bytes (at least 1) |
| dat_valid | input | 1 | Frame data word present |
| dat_ready | output | 1 | Engine takes a data word |
| dat_data | input | 32 | Frame data word, first byte in bits 7:0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Receive interrupt |

## Verification
The properties assume that memory raises mem_ack for one cycle only while a request is pending. They also assume that data words are offered only for a frame whose header was taken, that frame lengths are nonzero, and that start pointers are not rewritten while a frame is being placed. The bench keeps to these assumptions. Its memory model acknowledges a pending request at a falling edge and withdraws the acknowledge at the next falling edge. Frames go in one at a time, and the next frame starts only after the engine has returned to idle. Ring setup and memory edits happen only between frames.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int REG_AW       = 4;
    localparam int REG_CUR_BASE = 4;
    localparam int REG_CAUSE    = 8;
    localparam int REG_MASK     = 9;
    localparam int REG_HOFS     = 10;
    localparam int REG_DROPS    = 11;
    localparam int OWN_BIT      = 31;

    typedef enum logic [3:0] {
        W_IDLE, W_PICK, W_FETCH, W_EVAL, W_NEXT, W_DGET, W_DPUT, W_WB, W_DROP
    } wstate_e;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
    import rxr_pkg::*;
#(
    parameter int NUM_RINGS = 4,
    parameter int CNT_W     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr_i,
    input  logic [REG_AW-1:0]          reg_addr_i,
    input  logic [31:0]                reg_wdata_i,
    output logic [31:0]                reg_rdata_o,
    input  logic                       acc_i,
    input  logic [$clog2(NUM_RINGS)-1:0] acc_ring_i,
    input  logic [31:0]                acc_next_i,
    input  logic                       drop_i,
    output logic [NUM_RINGS-1:0][31:0] start_o,
    output logic [NUM_RINGS-1:0][31:0] cur_o,
    output logic [15:0]                hofs_o,
    output logic                       mask_o,
    output logic [CNT_W-1:0]           drops_o,
    output logic                       irq_o
);
    localparam int RIDX_W = $clog2(NUM_RINGS);

    typedef struct packed {
        logic [NUM_RINGS-1:0][31:0] start;
        logic [NUM_RINGS-1:0][31:0] cur;
        logic                       cause;
        logic                       mask;
        logic [15:0]                hofs;
        logic [CNT_W-1:0]           drops;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (drop_i) r_d.drops = r_q.drops + 1'b1;
        if (acc_i)  r_d.cur[acc_ring_i] = acc_next_i;
        if (reg_wr_i) begin
            if (reg_addr_i < REG_AW'(NUM_RINGS)) begin
                r_d.start[reg_addr_i[RIDX_W-1:0]] = reg_wdata_i;
                r_d.cur[reg_addr_i[RIDX_W-1:0]]   = reg_wdata_i;
            end
            case (reg_addr_i)
                REG_AW'(REG_CAUSE): if (reg_wdata_i[0]) r_d.cause = 1'b0;
                REG_AW'(REG_MASK):  r_d.mask = reg_wdata_i[0];
                REG_AW'(REG_HOFS):  r_d.hofs = {reg_wdata_i[15:2], 2'b00};
                default: ;
            endcase
        end
        if (acc_i) r_d.cause = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        for (int i = 0; i < NUM_RINGS; i++) begin
            if (reg_addr_i == REG_AW'(i))                reg_rdata_o = r_q.start[i];
            if (reg_addr_i == REG_AW'(REG_CUR_BASE + i)) reg_rdata_o = r_q.cur[i];
        end
        case (reg_addr_i)
            REG_AW'(REG_CAUSE): reg_rdata_o = {31'b0, r_q.cause};
            REG_AW'(REG_MASK):  reg_rdata_o = {31'b0, r_q.mask};
            REG_AW'(REG_HOFS):  reg_rdata_o = {16'b0, r_q.hofs};
            REG_AW'(REG_DROPS): reg_rdata_o = 32'(r_q.drops);
            default: ;
        endcase
    end

    assign start_o = r_q.start;
    assign cur_o   = r_q.cur;
    assign hofs_o  = r_q.hofs;
    assign mask_o  = r_q.mask;
    assign drops_o = r_q.drops;
    assign irq_o   = r_q.cause & r_q.mask;
endmodule

// File: rtl/rxr_walker.sv
module rxr_walker
    import rxr_pkg::*;
#(
    parameter int NUM_RINGS = 4,
    parameter int LEN_W     = 16,
    parameter int MAX_WALK  = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hdr_valid_i,
    output logic                         hdr_ready_o,
    input  logic [LEN_W-1:0]             hdr_len_i,
    input  logic                         dat_valid_i,
    output logic                         dat_ready_o,
    input  logic [31:0]                  dat_data_i,
    output logic                         mem_req_o,
    output logic                         mem_we_o,
    output logic [31:0]                  mem_addr_o,
    output logic [31:0]                  mem_wdata_o,
    input  logic                         mem_ack_i,
    input  logic [31:0]                  mem_rdata_i,
    input  logic [NUM_RINGS-1:0][31:0]   start_i,
    input  logic [NUM_RINGS-1:0][31:0]   cur_i,
    input  logic [15:0]                  hofs_i,
    output logic                         acc_o,
    output logic [$clog2(NUM_RINGS)-1:0] acc_ring_o,
    output logic [31:0]                  acc_next_o,
    output logic                         drop_o
);
    localparam int RIDX_W = $clog2(NUM_RINGS);
    localparam int HOP_W  = $clog2(MAX_WALK + 1);

    typedef struct packed {
        wstate_e           st;
        logic [RIDX_W-1:0] ring;
        logic [31:0]       dptr;
        logic [1:0]        widx;
        logic [31:0]       cmd;
        logic [15:0]       bsize;
        logic [31:0]       bufa;
        logic [31:0]       nxt;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  wcnt;
        logic [HOP_W-1:0]  hops;
        logic [31:0]       wdat;
    } wk_t;

    wk_t q, d;
    logic [LEN_W:0]   nwords;
    logic [LEN_W-1:0] last_w;

    assign nwords = ({1'b0, q.len} + (LEN_W+1)'(3)) >> 2;
    assign last_w = LEN_W'(nwords - 1'b1);

    always_comb begin
        d      = q;
        acc_o  = 1'b0;
        drop_o = 1'b0;
        case (q.st)
            W_IDLE: if (hdr_valid_i) begin
                d.len = hdr_len_i; d.ring = '0; d.wcnt = '0; d.st = W_PICK;
            end
            W_PICK: begin
                if (cur_i[q.ring] == '0) d.st = W_NEXT;
                else begin
                    d.dptr = cur_i[q.ring]; d.widx = '0; d.hops = '0; d.st = W_FETCH;
                end
            end
            W_FETCH: if (mem_ack_i) begin
                case (q.widx)
                    2'd0: d.cmd   = mem_rdata_i;
                    2'd1: d.bsize = mem_rdata_i[31:16];
                    2'd2: d.bufa  = mem_rdata_i;
                    default: d.nxt = mem_rdata_i;
                endcase
                d.widx = q.widx + 1'b1;
                if (q.widx == 2'd3) d.st = W_EVAL;
            end
            W_EVAL: begin
                if (q.cmd[OWN_BIT] && (32'(q.bsize) >= 32'(q.len))) begin
                    d.wcnt = '0; d.st = W_DGET;
                end else if (q.nxt == start_i[q.ring] || q.hops == HOP_W'(MAX_WALK - 1)) begin
                    d.st = W_NEXT;
                end else begin
                    d.dptr = q.nxt; d.widx = '0; d.hops = q.hops + 1'b1; d.st = W_FETCH;
                end
            end
            W_NEXT: begin
                if (q.ring == RIDX_W'(NUM_RINGS - 1)) begin
                    d.wcnt = '0; d.st = W_DROP;
                end else begin
                    d.ring = q.ring + 1'b1; d.st = W_PICK;
                end
            end
            W_DGET: if (dat_valid_i) begin
                d.wdat = dat_data_i; d.st = W_DPUT;
            end
            W_DPUT: if (mem_ack_i) begin
                if (q.wcnt == last_w) begin
                    d.widx = '0; d.st = W_WB;
                end else begin
                    d.wcnt = q.wcnt + 1'b1; d.st = W_DGET;
                end
            end
            W_WB: if (mem_ack_i) begin
                if (q.widx == 2'd0) d.widx = 2'd1;
                else begin
                    acc_o = 1'b1; d.st = W_IDLE;
                end
            end
            W_DROP: if (dat_valid_i) begin
                if (q.wcnt == last_w) begin
                    drop_o = 1'b1; d.st = W_IDLE;
                end else d.wcnt = q.wcnt + 1'b1;
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        mem_req_o   = (q.st == W_FETCH) || (q.st == W_DPUT) || (q.st == W_WB);
        mem_we_o    = (q.st == W_DPUT) || (q.st == W_WB);
        mem_addr_o  = q.dptr + 32'({q.widx, 2'b00});
        mem_wdata_o = '0;
        if (q.st == W_DPUT) begin
            mem_addr_o  = q.bufa + 32'(hofs_i) + 32'({q.wcnt, 2'b00});
            mem_wdata_o = q.wdat;
        end else if (q.st == W_WB) begin
            if (q.widx == 2'd0) mem_wdata_o = q.cmd & ~(32'd1 << OWN_BIT);
            else mem_wdata_o = {q.bsize, 16'(32'(q.len) + 32'(hofs_i))};
        end
    end

    assign hdr_ready_o = (q.st == W_IDLE);
    assign dat_ready_o = (q.st == W_DGET) || (q.st == W_DROP);
    assign acc_ring_o  = q.ring;
    assign acc_next_o  = q.nxt;
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
    import rxr_pkg::*;
#(
    parameter int NUM_RINGS = 4,
    parameter int MAX_WALK  = 64,
    parameter int CNT_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hdr_valid,
    output logic        hdr_ready,
    input  logic [15:0] hdr_len,
    input  logic        dat_valid,
    output logic        dat_ready,
    input  logic [31:0] dat_data,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int RIDX_W = $clog2(NUM_RINGS);

    logic [NUM_RINGS-1:0][31:0] start_w, cur_w;
    logic [15:0]                hofs_w;
    logic                       mask_w;
    logic [CNT_W-1:0]           drops_w;
    logic                       acc_w, drop_w;
    logic [RIDX_W-1:0]          acc_ring_w;
    logic [31:0]                acc_next_w;

    rxr_regs #(.NUM_RINGS(NUM_RINGS), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .acc_i(acc_w), .acc_ring_i(acc_ring_w), .acc_next_i(acc_next_w),
        .drop_i(drop_w),
        .start_o(start_w), .cur_o(cur_w), .hofs_o(hofs_w), .mask_o(mask_w),
        .drops_o(drops_w), .irq_o(irq)
    );

    rxr_walker #(.NUM_RINGS(NUM_RINGS), .LEN_W(16), .MAX_WALK(MAX_WALK)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid_i(hdr_valid), .hdr_ready_o(hdr_ready), .hdr_len_i(hdr_len),
        .dat_valid_i(dat_valid), .dat_ready_o(dat_ready), .dat_data_i(dat_data),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .start_i(start_w), .cur_i(cur_w), .hofs_i(hofs_w),
        .acc_o(acc_w), .acc_ring_o(acc_ring_w), .acc_next_o(acc_next_w),
        .drop_o(drop_w)
    );
endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk #(
    parameter int NUM_RINGS = 4,
    parameter int CNT_W     = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr,
    input logic [3:0]                 reg_addr,
    input logic [31:0]                reg_wdata,
    input logic                       irq,
    input logic                       mem_req,
    input logic                       mem_we,
    input logic                       mem_ack,
    input logic [31:0]                mem_addr,
    input logic [31:0]                mem_wdata,
    input logic                       hdr_valid,
    input logic                       hdr_ready,
    input logic                       acc_w,
    input logic                       drop_w,
    input logic                       mask_w,
    input logic [CNT_W-1:0]           drops_w,
    input logic [NUM_RINGS-1:0][31:0] cur_w
);
    AST_START_LOADS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr < 4'(NUM_RINGS)) |=> cur_w[$past(reg_addr)] == $past(reg_wdata)); // R1

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10

    AST_ONE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |=> !hdr_ready); // R10

    AST_ACC_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_w && mask_w && !(reg_wr && reg_addr == 4'd9)) |=> irq); // R8

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'd8 && reg_wdata[0] && !acc_w) |=> !irq); // R8

    AST_DROP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        drop_w |=> drops_w == $past(drops_w) + 1'b1); // R9

    AST_DROP_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        drop_w |-> !acc_w && !mem_req); // R9
endmodule

bind rx_ring_dma rx_ring_dma_chk #(.NUM_RINGS(NUM_RINGS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .acc_w(acc_w),
    .drop_w(drop_w), .mask_w(mask_w), .drops_w(drops_w), .cur_w(cur_w)
);

// File: tb/tb_rx_ring_dma.sv
`timescale 1ns/100ps
module tb_rx_ring_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic [15:0] hdr_len = '0;
    logic        dat_valid = 1'b0;
    logic        dat_ready;
    logic [31:0] dat_data = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    logic [31:0] mem [0:255];
    logic [31:0] exp_a[$];
    logic [31:0] exp_d[$];

    always #2.5 clk = ~clk;

    rx_ring_dma dut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_len(hdr_len), .dat_valid(dat_valid), .dat_ready(dat_ready),
        .dat_data(dat_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] word_of(int seed, int k);
        return 32'hD000_0000 | 32'(seed << 8) | 32'(k);
    endfunction

    // Memory responder and scoreboard monitor: pops expected writes as they occur
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req && rst_n) begin
                if (mem_addr[31:10] != '0) check("R2 address range", mem_addr, 32'h0);
                if (mem_we) begin
                    if (exp_a.size() == 0) begin
                        check("R9 unexpected write addr", mem_addr, 32'hFFFF_FFFF);
                    end else begin
                        check("R6/R7 write address", mem_addr, exp_a.pop_front());
                        check("R6/R7 write data", mem_wdata, exp_d.pop_front());
                    end
                    mem[mem_addr[9:2]] = mem_wdata;
                end else begin
                    mem_rdata = mem[mem_addr[9:2]];
                end
                mem_ack = 1'b1;
            end
        end
    end

    task automatic put_desc(int a, logic [31:0] cmd, logic [15:0] sz, logic [31:0] b, logic [31:0] nx);
        mem[a/4]     = cmd;
        mem[a/4 + 1] = {sz, 16'h0};
        mem[a/4 + 2] = b;
        mem[a/4 + 3] = nx;
    endtask

    task automatic reg_write(int a, logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 v = reg_rdata;
    endtask

    // Driver: pushes the expected memory writes of an accepted frame
    task automatic expect_accept(int len, int seed, int desc, logic [31:0] cmd,
                                 logic [15:0] sz, logic [31:0] b, int ofs);
        for (int k = 0; k < (len + 3) / 4; k++) begin
            exp_a.push_back(b + 32'(ofs) + 32'(4 * k));
            exp_d.push_back(word_of(seed, k));
        end
        exp_a.push_back(32'(desc));     exp_d.push_back(cmd & 32'h7FFF_FFFF);
        exp_a.push_back(32'(desc + 4)); exp_d.push_back({sz, 16'(len + ofs)});
    endtask

    task automatic send_frame(int len, int seed);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_len = 16'(len);
        while (!hdr_ready) @(negedge clk);
        @(posedge clk); #1 hdr_valid = 1'b0;
        for (int k = 0; k < (len + 3) / 4; k++) begin
            dat_valid = 1'b1; dat_data = word_of(seed, k);
            @(negedge clk);
            while (!dat_ready) @(negedge clk);
            @(posedge clk); #1;
        end
        dat_valid = 1'b0;
        @(negedge clk);
        while (!hdr_ready) @(negedge clk);
        check("R7 all scoreboard writes seen", 32'(exp_a.size()), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset hdr_ready", 32'(hdr_ready), 32'd1);
        check("R8 reset irq", 32'(irq), 32'd0);
        reg_read(8, v);  check("R8 reset cause", v, 32'd0);
        reg_read(11, v); check("R9 reset drop count", v, 32'd0);
        reg_read(4, v);  check("R1 reset current ring0", v, 32'd0);

        // ring1: A (too small) -> B -> A ; ring2: C self loop; ring0 stays zero (R3)
        put_desc(32'h100, 32'h8000_00A1, 16'd4,  32'h280, 32'h110);
        put_desc(32'h110, 32'h8000_00B2, 16'd64, 32'h200, 32'h100);
        put_desc(32'h120, 32'h8000_00C0, 16'd64, 32'h300, 32'h120);
        reg_write(9, 32'h1);
        reg_write(10, 32'h0000_000B);
        reg_read(10, v); check("R6 header offset low bits zero", v, 32'h8);
        reg_write(1, 32'h100);
        reg_write(2, 32'h120);
        reg_read(5, v); check("R1 current ring1 loaded", v, 32'h100);
        reg_read(1, v); check("R1 start ring1", v, 32'h100);

        // Frame 1: skips small A, lands in B of ring1 despite ring2 ready (R3, R5)
        expect_accept(10, 1, 32'h110, 32'h8000_00B2, 16'd64, 32'h200, 8);
        send_frame(10, 1);
        reg_read(5, v); check("R7 ring1 current advanced", v, 32'h100);
        reg_read(8, v); check("R8 cause set", v, 32'd1);
        check("R8 irq with mask", 32'(irq), 32'd1);

        // Frame 2: length equals buffer size of A (R5 boundary)
        expect_accept(4, 2, 32'h100, 32'h8000_00A1, 16'd4, 32'h280, 8);
        send_frame(4, 2);
        reg_read(5, v); check("R7 ring1 current after A", v, 32'h110);

        // Clear cause (R8)
        reg_write(8, 32'h1);
        @(negedge clk);
        check("R8 irq after clear", 32'(irq), 32'd0);

        // Frame 3: ring1 walk from 0x110 ends at start, ring2 accepts (R4)
        expect_accept(8, 3, 32'h120, 32'h8000_00C0, 16'd64, 32'h300, 8);
        send_frame(8, 3);
        reg_read(6, v); check("R4 ring2 current", v, 32'h120);
        reg_read(5, v); check("R4 ring1 current unchanged", v, 32'h110);
        reg_write(8, 32'h1);

        // Frame 4: nothing owned -> drop (R9)
        send_frame(8, 4);
        reg_read(11, v); check("R9 drop count", v, 32'd1);
        reg_read(8, v);  check("R9 cause unchanged by drop", v, 32'd0);
        check("R9 irq stays low", 32'(irq), 32'd0);

        // Frame 5: masked acceptance (R8)
        reg_write(9, 32'h0);
        mem[32'h120/4] = 32'h8000_00C0;
        expect_accept(1, 5, 32'h120, 32'h8000_00C0, 16'd64, 32'h300, 8);
        send_frame(1, 5);
        reg_read(8, v); check("R8 cause set while masked", v, 32'd1);
        check("R8 irq masked", 32'(irq), 32'd0);
        reg_write(9, 32'h1);
        @(negedge clk);
        check("R8 irq after unmask", 32'(irq), 32'd1);
        reg_write(8, 32'h1);

        // Frame 6: ring3 chain never returns to start; walk is bounded (R4)
        put_desc(32'h130, 32'h0000_0000, 16'd64, 32'h380, 32'h140);
        put_desc(32'h140, 32'h0000_0000, 16'd64, 32'h380, 32'h140);
        reg_write(3, 32'h130);
        reg_read(7, v); check("R1 current ring3 loaded", v, 32'h130);
        send_frame(12, 6);
        reg_read(11, v); check("R4 bounded walk dropped", v, 32'd2);
        check("R10 idle after bounded walk", 32'(hdr_ready), 32'd1);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule